// File: doc/BRIEF.md
# Format-Tagged Floating-Point Register File

This block is a bank of floating-point registers in which every entry carries a tag recording how its contents were last written or first read: single, word, double, long, uninterpreted or unknown. A register that has never been given a meaning starts out uninterpreted and adopts the format of the first read that touches it. A later read in a different format does not hand back the stored bits. It returns a fixed quiet-NaN pattern chosen by the requested format, and it poisons the tag to unknown, so every later typed read also sees the NaN pattern.

A `wide` input selects the register width. With `wide` high, each register holds a full 64-bit value. With `wide` low, only 32 bits per register are kept, and a 64-bit value lives in an even/odd pair: the even index holds the lower half and the next index holds the upper half. A 64-bit access to an odd index in that mode is flagged as a reserved-instruction error. Writes that carry no legal format raise a bad-format fault and poison the tag. Reads are combinational. Writes and tag changes take effect on the rising clock edge.

Each tag is a small state machine. Its states are UNINTERP, SINGLE, WORD, DOUBLE, LONG and UNKNOWN, and its transitions are:
- **LOAD**: a write sets the tag.
- **CLAIM**: the first read of an UNINTERP register takes on the read format.
- **POISON**: a read whose format differs from the tag moves the tag to UNKNOWN.
- **HOLD**: in every other case the tag keeps its value.

Top module: `fpr_tagged_file`

## Requirements
- R1: Format codes on `rd_fmt`/`wr_fmt` are 0 single, 1 double, 2 word, 3 long, 4 uninterpreted, 5 unknown, 6 raw 32-bit, 7 raw 64-bit. After reset every tag is uninterpreted and every register holds zero, so a single read of any register returns 0 with no flags raised.
- R2: A read in format 0..3 of an uninterpreted-tagged register returns its data and sets the tag to that format. A later read in the same format returns the data.
- R3: A read in a format that differs from a register's single/word/double/long tag sets the tag to unknown. Any typed read of an unknown-tagged register returns a quiet NaN: 0x7FBFFFFF for single, 0x7FFFFFFF for word, 0x7FF7FFFFFFFFFFFF for double, 0x7FFFFFFFFFFFFFFF for long.
- R4: A read requested with code 4 or 5 is treated as a read in the register's current tag. If that tag is unknown, the read raises `rd_fault` and returns 0.
- R5: Single and word reads return the low 32 bits of the register, zero-extended, in both modes.
- R6: With `wide` high, a single, word or raw 32-bit write stores the low 32 data bits and fills the upper 32 bits with 0xDEADC0DE.
- R7: With `wide` low, a 32-bit-class write stores only the low 32 bits. The upper half of that register reads as zero afterwards.
- R8: With `wide` low, a double, long, uninterpreted or raw 64-bit access to an even index N places the lower half in register N and the upper half in register N+1. A write of this kind tags both registers.
- R9: With `wide` low, a 64-bit-class access to an odd index raises the reserved error. A read of this kind returns 0. A write of this kind sets the tags of N and N+1 to unknown.
- R10: Raw 32-bit and raw 64-bit writes store the uninterpreted tag.
- R11: A write with code 5 raises `wr_fault` and sets the tag to unknown. A read with code 6 or 7 raises `rd_fault`, returns 0 and leaves the tag unchanged.
- R12: Read data shows the state before the clock edge. When a write and a read touch the same register in one cycle, the write sets the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wide | input | 1 | 1: 64-bit registers, 0: 32-bit registers with pairing |
| rd_en | input | 1 | Read request; enables the tag update at the edge |
| rd_idx | input | $clog2(NREG) | Read register index |
| rd_fmt | input | 3 | Requested read format code |
| rd_data | output | 64 | Read result (combinational) |
| rd_resv | output | 1 | Reserved error on the read |
| rd_fault | output | 1 | Bad-format fault on the read |
| wr_en | input | 1 | Write request |
| wr_idx | input | $clog2(NREG) | Write register index |
| wr_fmt | input | 3 | Write format code |
| wr_data | input | 64 | Write data |
| wr_resv | output | 1 | Reserved error on the write |
| wr_fault | output | 1 | Bad-format fault on the write |

## Verification
The bench builds the block with NREG set to 8. At that size it can claim every register after a reset once for each of the four typed formats. It then re-reads every register in a second format, so every pairing of claim format and read format is covered, along with the NaN pattern of each format. The small bank also puts the top odd index, whose partner does not exist, and every even/odd pair within a few cycles. Directed sequences then cover the mode switch, the fill constant, the same-cycle read/write collision and the fault codes.

// File: rtl/fpr_pkg.sv
package fpr_pkg;

    typedef enum logic [2:0] {
        FMT_SINGLE   = 3'd0,
        FMT_DOUBLE   = 3'd1,
        FMT_WORD     = 3'd2,
        FMT_LONG     = 3'd3,
        FMT_UNINTERP = 3'd4,
        FMT_UNKNOWN  = 3'd5,
        FMT_RAW32    = 3'd6,
        FMT_RAW64    = 3'd7
    } fmt_e;

    localparam int WORD_W = 64;
    localparam int HALF_W = WORD_W / 2;

    function automatic logic [WORD_W-1:0] quiet_nan(fmt_e f);
        logic [WORD_W-1:0] v;
        case (f)
            FMT_SINGLE: v = 64'h0000_0000_7FBF_FFFF;
            FMT_WORD:   v = 64'h0000_0000_7FFF_FFFF;
            FMT_DOUBLE: v = 64'h7FF7_FFFF_FFFF_FFFF;
            FMT_LONG:   v = 64'h7FFF_FFFF_FFFF_FFFF;
            default:    v = '0;
        endcase
        return v;
    endfunction

    function automatic logic is_half_fmt(fmt_e f);
        return (f == FMT_SINGLE) || (f == FMT_WORD) || (f == FMT_RAW32);
    endfunction

    function automatic logic is_full_fmt(fmt_e f);
        return (f == FMT_DOUBLE) || (f == FMT_LONG) ||
               (f == FMT_UNINTERP) || (f == FMT_RAW64);
    endfunction

endpackage

// File: rtl/fpr_tag_cell.sv
// One register's format tag, held as a small state machine.
module fpr_tag_cell
    import fpr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_en,
    input  fmt_e ld_tag,
    input  logic rd_touch,
    input  fmt_e rd_eff,
    output fmt_e tag_o
);

    fmt_e state_q;
    fmt_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FMT_UNINTERP;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: LOAD beats CLAIM/POISON; otherwise HOLD
    always_comb begin
        state_d = state_q;
        if (ld_en) begin
            state_d = ld_tag;                        // LOAD
        end else if (rd_touch) begin
            unique case (state_q)
                FMT_UNINTERP: state_d = rd_eff;      // CLAIM
                FMT_UNKNOWN:  state_d = FMT_UNKNOWN; // HOLD
                FMT_SINGLE, FMT_WORD, FMT_DOUBLE, FMT_LONG: begin
                    if (rd_eff != state_q) begin
                        state_d = FMT_UNKNOWN;       // POISON
                    end
                end
                default:      state_d = FMT_UNKNOWN;
            endcase
        end
    end

    // Output
    assign tag_o = state_q;

endmodule

// File: rtl/fpr_read_path.sv
// Combinational read: format resolution, NaN substitution, pairing.
module fpr_read_path
    import fpr_pkg::*;
(
    input  logic              wide,
    input  logic              rd_en,
    input  logic              rd_odd,
    input  logic [2:0]        rd_fmt,
    input  fmt_e              cur_tag,
    input  logic [WORD_W-1:0] lo_word,
    input  logic [HALF_W-1:0] pair_lo,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_resv,
    output logic              rd_fault,
    output logic              rd_touch,
    output fmt_e              rd_eff
);

    fmt_e req;
    fmt_e post;
    logic legal;

    always_comb begin
        req   = fmt_e'(rd_fmt);
        legal = (req != FMT_RAW32) && (req != FMT_RAW64);
        rd_eff = ((req == FMT_UNINTERP) || (req == FMT_UNKNOWN)) ? cur_tag : req;
        post   = (cur_tag == FMT_UNINTERP) ? rd_eff : cur_tag;
        if (rd_eff != post) begin
            post = FMT_UNKNOWN;
        end

        rd_data  = '0;
        rd_resv  = 1'b0;
        rd_fault = 1'b0;

        if (!legal) begin
            rd_fault = 1'b1;
        end else if (post == FMT_UNKNOWN) begin
            if (rd_eff == FMT_UNKNOWN) begin
                rd_fault = 1'b1;
            end else begin
                rd_data = quiet_nan(rd_eff);
            end
        end else if (rd_eff == FMT_SINGLE || rd_eff == FMT_WORD) begin
            rd_data = {{HALF_W{1'b0}}, lo_word[HALF_W-1:0]};
        end else if (wide) begin
            rd_data = lo_word;
        end else if (rd_odd) begin
            rd_resv = 1'b1;
        end else begin
            rd_data = {pair_lo, lo_word[HALF_W-1:0]};
        end

        rd_touch = rd_en && legal;
    end

endmodule

// File: rtl/fpr_write_decode.sv
// Write decode: data placement and tag loads for index N and N+1.
module fpr_write_decode
    import fpr_pkg::*;
#(
    parameter int NREG = 32,
    parameter int IDXW = $clog2(NREG),
    parameter logic [HALF_W-1:0] FILL_HI = 32'hDEADC0DE
) (
    input  logic              wide,
    input  logic              wr_en,
    input  logic [IDXW-1:0]   wr_idx,
    input  logic [2:0]        wr_fmt,
    input  logic [WORD_W-1:0] wr_data,
    output logic              a_dat_en,
    output logic [WORD_W-1:0] a_dat,
    output logic              a_tag_en,
    output fmt_e              a_tag,
    output logic [IDXW-1:0]   b_idx,
    output logic              b_dat_en,
    output logic [WORD_W-1:0] b_dat,
    output logic              b_tag_en,
    output fmt_e              b_tag,
    output logic              wr_resv,
    output logic              wr_fault
);

    fmt_e            f;
    fmt_e            keep_tag;
    logic [IDXW:0]   b_ext;
    logic            b_ok;

    always_comb begin
        f        = fmt_e'(wr_fmt);
        keep_tag = ((f == FMT_RAW32) || (f == FMT_RAW64)) ? FMT_UNINTERP : f;
        b_ext    = {1'b0, wr_idx} + 1'b1;
        b_ok     = (b_ext < (IDXW+1)'(NREG));
        b_idx    = b_ext[IDXW-1:0];

        a_dat_en = 1'b0;
        a_dat    = '0;
        a_tag_en = 1'b0;
        a_tag    = FMT_UNKNOWN;
        b_dat_en = 1'b0;
        b_dat    = '0;
        b_tag_en = 1'b0;
        b_tag    = FMT_UNKNOWN;
        wr_resv  = 1'b0;
        wr_fault = 1'b0;

        if (wr_en) begin
            if (is_half_fmt(f)) begin
                a_dat_en = 1'b1;
                a_dat    = {(wide ? FILL_HI : {HALF_W{1'b0}}), wr_data[HALF_W-1:0]};
                a_tag_en = 1'b1;
                a_tag    = keep_tag;
            end else if (is_full_fmt(f)) begin
                if (wide) begin
                    a_dat_en = 1'b1;
                    a_dat    = wr_data;
                    a_tag_en = 1'b1;
                    a_tag    = keep_tag;
                end else if (!wr_idx[0]) begin
                    a_dat_en = 1'b1;
                    a_dat    = {{HALF_W{1'b0}}, wr_data[HALF_W-1:0]};
                    a_tag_en = 1'b1;
                    a_tag    = keep_tag;
                    b_dat_en = 1'b1;
                    b_dat    = {{HALF_W{1'b0}}, wr_data[WORD_W-1:HALF_W]};
                    b_tag_en = 1'b1;
                    b_tag    = keep_tag;
                end else begin
                    wr_resv  = 1'b1;
                    a_tag_en = 1'b1;
                    b_tag_en = b_ok;
                end
            end else begin
                wr_fault = 1'b1;
                a_tag_en = 1'b1;
            end
        end
    end

endmodule

// File: rtl/fpr_tagged_file.sv
// Format-tagged floating-point register bank. NREG must be a power of two.
module fpr_tagged_file
    import fpr_pkg::*;
#(
    parameter int NREG = 32,
    parameter logic [31:0] FILL_HI = 32'hDEADC0DE,
    localparam int IDXW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wide,
    input  logic            rd_en,
    input  logic [IDXW-1:0] rd_idx,
    input  logic [2:0]      rd_fmt,
    output logic [63:0]     rd_data,
    output logic            rd_resv,
    output logic            rd_fault,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [2:0]      wr_fmt,
    input  logic [63:0]     wr_data,
    output logic            wr_resv,
    output logic            wr_fault
);

    fmt_e              tags   [NREG];
    logic [WORD_W-1:0] regs_q [NREG];

    logic              a_dat_en, a_tag_en, b_dat_en, b_tag_en;
    logic [WORD_W-1:0] a_dat, b_dat;
    fmt_e              a_tag, b_tag;
    logic [IDXW-1:0]   b_idx;
    logic              rd_touch;
    fmt_e              rd_eff;
    logic [IDXW-1:0]   pair_idx;

    fpr_write_decode #(
        .NREG    (NREG),
        .IDXW    (IDXW),
        .FILL_HI (FILL_HI)
    ) u_wdec (
        .wide     (wide),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_fmt   (wr_fmt),
        .wr_data  (wr_data),
        .a_dat_en (a_dat_en),
        .a_dat    (a_dat),
        .a_tag_en (a_tag_en),
        .a_tag    (a_tag),
        .b_idx    (b_idx),
        .b_dat_en (b_dat_en),
        .b_dat    (b_dat),
        .b_tag_en (b_tag_en),
        .b_tag    (b_tag),
        .wr_resv  (wr_resv),
        .wr_fault (wr_fault)
    );

    assign pair_idx = rd_idx | IDXW'(1);

    fpr_read_path u_rpath (
        .wide     (wide),
        .rd_en    (rd_en),
        .rd_odd   (rd_idx[0]),
        .rd_fmt   (rd_fmt),
        .cur_tag  (tags[rd_idx]),
        .lo_word  (regs_q[rd_idx]),
        .pair_lo  (regs_q[pair_idx][HALF_W-1:0]),
        .rd_data  (rd_data),
        .rd_resv  (rd_resv),
        .rd_fault (rd_fault),
        .rd_touch (rd_touch),
        .rd_eff   (rd_eff)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_a, hit_b;
        assign hit_a = (wr_idx == IDXW'(g));
        assign hit_b = (b_idx == IDXW'(g));

        fpr_tag_cell u_tag (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_en    ((a_tag_en && hit_a) || (b_tag_en && hit_b)),
            .ld_tag   ((a_tag_en && hit_a) ? a_tag : b_tag),
            .rd_touch (rd_touch && (rd_idx == IDXW'(g))),
            .rd_eff   (rd_eff),
            .tag_o    (tags[g])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (a_dat_en && hit_a) begin
                regs_q[g] <= a_dat;
            end else if (b_dat_en && hit_b) begin
                regs_q[g] <= b_dat;
            end
        end
    end

endmodule

// File: rtl/fpr_tagged_file_chk.sv
module fpr_tagged_file_chk
    import fpr_pkg::*;
#(
    parameter int NREG = 32,
    parameter int IDXW = $clog2(NREG)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wide,
    input logic            rd_en,
    input logic [IDXW-1:0] rd_idx,
    input logic [2:0]      rd_fmt,
    input logic [63:0]     rd_data,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx,
    input logic [2:0]      wr_fmt,
    input logic            wr_resv,
    input fmt_e            tags [NREG]
);

    // R2: first typed read of an uninterpreted register claims its format
    p_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rd_fmt <= 3'd3 && tags[rd_idx] == FMT_UNINTERP)
        |=> (tags[$past(rd_idx)] == fmt_e'($past(rd_fmt))));

    // R3: a mismatching typed read poisons the tag
    p_poison_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && rd_fmt <= 3'd3 && tags[rd_idx] <= FMT_LONG &&
         tags[rd_idx] != fmt_e'(rd_fmt))
        |=> (tags[$past(rd_idx)] == FMT_UNKNOWN));

    // R5: single/word reads never carry upper bits
    p_low_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (rd_fmt == 3'd0 || rd_fmt == 3'd2)) |-> (rd_data[63:32] == 32'h0));

    // R9: narrow 64-bit write to an odd index is reserved
    p_odd_pair_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && wr_en && wr_idx[0] &&
         (wr_fmt == 3'd1 || wr_fmt == 3'd3 || wr_fmt == 3'd7)) |-> wr_resv);

    // R11: a write with the unknown code leaves the tag unknown
    p_bad_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_fmt == 3'd5) |=> (tags[$past(wr_idx)] == FMT_UNKNOWN));

endmodule

bind fpr_tagged_file fpr_tagged_file_chk #(.NREG(NREG), .IDXW(IDXW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wide    (wide),
    .rd_en   (rd_en),
    .rd_idx  (rd_idx),
    .rd_fmt  (rd_fmt),
    .rd_data (rd_data),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_fmt  (wr_fmt),
    .wr_resv (wr_resv),
    .tags    (tags)
);

// File: tb/test_fpr_tagged_file.sv
module test_fpr_tagged_file;

    localparam int NR = 8;
    localparam int IW = $clog2(NR);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wide = 1'b1;
    logic          rd_en = 1'b0;
    logic [IW-1:0] rd_idx = '0;
    logic [2:0]    rd_fmt = '0;
    logic [63:0]   rd_data;
    logic          rd_resv, rd_fault;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [2:0]    wr_fmt = '0;
    logic [63:0]   wr_data = '0;
    logic          wr_resv, wr_fault;

    int n_tests = 0;
    int n_fail  = 0;

    logic [63:0] d;
    logic        rs, fl;

    always #5 clk = ~clk;

    fpr_tagged_file #(.NREG(NR)) i_fpr_tagged_file (
        .clk(clk), .rst_n(rst_n), .wide(wide),
        .rd_en(rd_en), .rd_idx(rd_idx), .rd_fmt(rd_fmt),
        .rd_data(rd_data), .rd_resv(rd_resv), .rd_fault(rd_fault),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_fmt(wr_fmt), .wr_data(wr_data),
        .wr_resv(wr_resv), .wr_fault(wr_fault)
    );

    function automatic logic [63:0] qn(int f);
        case (f)
            0: return 64'h0000_0000_7FBF_FFFF;
            2: return 64'h0000_0000_7FFF_FFFF;
            1: return 64'h7FF7_FFFF_FFFF_FFFF;
            default: return 64'h7FFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

    function automatic logic [63:0] typed(int f, logic [63:0] v);
        return (f == 0 || f == 2) ? {32'h0, v[31:0]} : v;
    endfunction

    function automatic logic [63:0] pat(int i);
        return 64'hF0E1_D2C3_B4A5_9687 + 64'(i) * 64'h0101_0101_0101_0101;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rd_en = 1'b0;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic rd(input int idx, input int f,
                      output logic [63:0] od, output logic ors, output logic ofl);
        @(negedge clk);
        rd_en  = 1'b1;
        rd_idx = IW'(idx);
        rd_fmt = 3'(f);
        #2;
        od  = rd_data;
        ors = rd_resv;
        ofl = rd_fault;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wr(input int idx, input int f, input logic [63:0] v,
                      output logic ors, output logic ofl);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_idx  = IW'(idx);
        wr_fmt  = 3'(f);
        wr_data = v;
        #2;
        ors = wr_resv;
        ofl = wr_fault;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset();
        rd(0, 0, d, rs, fl);
        check("R1 reset data", d, 64'h0);
        check("R1 reset flags", {62'h0, rs, fl}, 64'h0);

        // Sweep: claim every register in format a, then read in format b (R2, R3, R5)
        for (int a = 0; a < 4; a++) begin
            do_reset();
            wide = 1'b1;
            for (int i = 0; i < NR; i++) wr(i, 7, pat(i), rs, fl);
            for (int i = 0; i < NR; i++) begin
                int b;
                b = i % 4;
                rd(i, a, d, rs, fl);
                check("R2 claim read", d, typed(a, pat(i)));
                rd(i, b, d, rs, fl);
                check("R3 second-format read", d, (a == b) ? typed(b, pat(i)) : qn(b));
                rd(i, a, d, rs, fl);
                check("R3 re-read claimed format", d, (a == b) ? typed(a, pat(i)) : qn(a));
            end
        end

        // Wide mode directed cases
        do_reset();
        wide = 1'b1;
        wr(1, 6, 64'h1111_2222_3333_4444, rs, fl);
        rd(1, 4, d, rs, fl);
        check("R6 fill constant", d, 64'hDEAD_C0DE_3333_4444);
        rd(1, 1, d, rs, fl);
        check("R10 raw32 keeps uninterpreted tag", d, 64'hDEAD_C0DE_3333_4444);

        wr(2, 0, 64'hFFFF_0000_1234_5678, rs, fl);
        rd(2, 0, d, rs, fl);
        check("R5 single read low half", d, 64'h0000_0000_1234_5678);
        rd(2, 5, d, rs, fl);
        check("R4 unknown request uses tag", d, 64'h0000_0000_1234_5678);
        check("R4 no fault", {63'h0, fl}, 64'h0);
        rd(2, 2, d, rs, fl);
        check("R3 word NaN", d, 64'h0000_0000_7FFF_FFFF);
        rd(2, 4, d, rs, fl);
        check("R4 uninterp request on unknown tag faults", {63'h0, fl}, 64'h1);
        check("R4 faulting read data", d, 64'h0);

        wr(3, 5, 64'h0123_4567_89AB_CDEF, rs, fl);
        check("R11 write fault", {63'h0, fl}, 64'h1);
        rd(3, 0, d, rs, fl);
        check("R11 tag unknown after bad write", d, 64'h0000_0000_7FBF_FFFF);

        wr(4, 2, 64'h0000_0000_0000_ABCD, rs, fl);
        rd(4, 6, d, rs, fl);
        check("R11 raw read code faults", {63'h0, fl}, 64'h1);
        check("R11 raw read data", d, 64'h0);
        rd(4, 2, d, rs, fl);
        check("R11 tag unchanged by raw read", d, 64'h0000_0000_0000_ABCD);

        // R12: same-cycle read and write of one register
        wr(5, 7, 64'hAAAA_0000_BBBB_1111, rs, fl);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = IW'(5); rd_fmt = 3'd0;
        wr_en = 1'b1; wr_idx = IW'(5); wr_fmt = 3'd7; wr_data = 64'hCCCC_2222_DDDD_3333;
        #2;
        check("R12 read shows pre-edge data", rd_data, 64'h0000_0000_BBBB_1111);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        rd(5, 1, d, rs, fl);
        check("R12 write tag wins", d, 64'hCCCC_2222_DDDD_3333);

        // Narrow mode
        do_reset();
        wide = 1'b0;
        wr(2, 1, 64'hAAAA_BBBB_CCCC_DDDD, rs, fl);
        check("R8 even pair no error", {63'h0, rs}, 64'h0);
        rd(2, 1, d, rs, fl);
        check("R8 pair read", d, 64'hAAAA_BBBB_CCCC_DDDD);
        rd(3, 0, d, rs, fl);
        check("R8 partner tagged double", d, 64'h0000_0000_7FBF_FFFF);

        wr(4, 6, 64'h5555_6666_7777_8888, rs, fl);
        wr(5, 6, 64'h9999_AAAA_BBBB_CCCC, rs, fl);
        rd(4, 4, d, rs, fl);
        check("R8 uninterpreted pair read", d, 64'hBBBB_CCCC_7777_8888);
        wide = 1'b1;
        rd(4, 4, d, rs, fl);
        check("R7 narrow write kept low half only", d, 64'h0000_0000_7777_8888);
        wide = 1'b0;

        wr(5, 3, 64'h1234_5678_9ABC_DEF0, rs, fl);
        check("R9 odd write reserved", {63'h0, rs}, 64'h1);
        rd(5, 2, d, rs, fl);
        check("R9 odd index poisoned", d, 64'h0000_0000_7FFF_FFFF);
        rd(6, 0, d, rs, fl);
        check("R9 partner poisoned", d, 64'h0000_0000_7FBF_FFFF);
        rd(1, 1, d, rs, fl);
        check("R9 odd read reserved", {63'h0, rs}, 64'h1);
        check("R9 odd read data", d, 64'h0);
        wr(7, 1, 64'h0F0F_0F0F_F0F0_F0F0, rs, fl);
        check("R9 top odd write reserved", {63'h0, rs}, 64'h1);

        wr(0, 2, 64'hFFFF_FFFF_0000_0042, rs, fl);
        rd(0, 2, d, rs, fl);
        check("R5 narrow word read", d, 64'h0000_0000_0000_0042);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule